// File: doc/BRIEF.md
# Condition Code Flag Unit

This block keeps the eight-bit condition code register of a 16/32-bit processor and works out its arithmetic flags. Each cycle the datapath presents an operation class, an operand size, the two source operands, the ALU result and the bit that a shifter pushed out. The unit derives carry, overflow and half-carry from the operands at the chosen size. It takes negative and zero from the sized result. On the next clock edge it writes the flags that the operation class affects into the register.

Software reaches the register through a second command path. It can load the whole byte, or combine the register with an immediate byte by AND, OR or XOR. The register value is always visible on the read port. A synchronous reset forces only the interrupt mask bit to 1. Every other bit keeps whatever it held before, so firmware must load the register before it relies on any flag.

Top module: `ccf_unit`

## Requirements
- R1: `ccr_o` shows the register. Bits are carry 0, overflow 1, zero 2, negative 3, user 4, half-carry 5, spare software bit 6 and interrupt mask 7. Software command `sw_op_i` = 1 (load) writes `sw_imm_i` into the register, and the new value is visible after the next rising edge.
- R2: Software commands 2, 3 and 4 replace the register with its bitwise AND, OR and XOR with `sw_imm_i`, one edge later.
- R3: When a software command (codes 1 to 4) and a flag-updating operation arrive in the same cycle, only the software command takes effect.
- R4: Add (`op_i` = 1) at byte, word or long size (`size_i` = 0, 1, 2; 3 acts as long) sets C to the carry out of the sized top bit and V to signed overflow. H is set to the carry out of bit 3, 11 or 27 respectively.
- R5: Subtract (`op_i` = 2) and compare (`op_i` = 3) compute opa − opb at the chosen size. C is the borrow out of the top bit, V is signed overflow and H is the borrow out of bit 3, 11 or 27.
- R6: Negate (`op_i` = 4) sets its flags as for 0 − opb at the chosen size.
- R7: For operation codes 1 to 6, N equals the top bit of `res_i` at the chosen size and Z is 1 exactly when those sized bits are all zero. Bits of `res_i`, `opa_i` and `opb_i` above the size have no effect.
- R8: Logical operations (`op_i` = 5) update N and Z, clear V, and leave C and H unchanged.
- R9: Shift/rotate operations (`op_i` = 6) update N and Z, load C from `shout_i`, clear V, and leave H unchanged.
- R10: With `op_i` = 0 (or 7) and no software command, the register is unchanged. Bits 4, 6 and 7 change only through software commands or reset.
- R11: While `rst` is high at a rising edge, bit 7 becomes 1 and bits 6..0 keep their value. Reset overrides any software command or flag update in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset (sets interrupt mask only) |
| op_i | input | 3 | Operation class: 0 none, 1 add, 2 sub, 3 compare, 4 negate, 5 logical, 6 shift/rotate |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| opa_i | input | 32 | First ALU operand |
| opb_i | input | 32 | Second ALU operand (the source for negate) |
| res_i | input | 32 | ALU result |
| shout_i | input | 1 | Bit shifted out of the end position |
| sw_op_i | input | 3 | Software command: 0 none, 1 load, 2 AND, 3 OR, 4 XOR |
| sw_imm_i | input | 8 | Immediate byte for software commands |
| ccr_o | output | 8 | Condition code register |

## Verification
The register is the only state, and it drives `ccr_o` directly. A wrong flag or a wrongly kept bit therefore shows on the port one edge after the cycle that caused it. The error stays there until the next write that covers that bit. A half-carry tap at the wrong bit, or a priority mistake between software and datapath writes, appears as a single wrong bit in the cycle right after the stimulus. Operations that preserve a bit let an earlier error carry forward, so each preserving case is checked against a known loaded value.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_CMP   = 3'd3,
        OP_NEG   = 3'd4,
        OP_LOGIC = 3'd5,
        OP_SHIFT = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        SW_NONE = 3'd0,
        SW_LOAD = 3'd1,
        SW_AND  = 3'd2,
        SW_OR   = 3'd3,
        SW_XOR  = 3'd4,
        SW_R5   = 3'd5,
        SW_R6   = 3'd6,
        SW_R7   = 3'd7
    } swop_e;

    localparam int CCR_W = 8;
    localparam int B_C   = 0;
    localparam int B_V   = 1;
    localparam int B_Z   = 2;
    localparam int B_N   = 3;
    localparam int B_U   = 4;
    localparam int B_H   = 5;
    localparam int B_UI  = 6;
    localparam int B_I   = 7;
    localparam int NSIZE = 3;

    typedef struct packed {
        logic c;
        logic v;
        logic h;
    } arith_t;

    typedef struct packed {
        logic n;
        logic z;
    } nz_t;

    function automatic logic sw_active(swop_e op);
        return (op == SW_LOAD) || (op == SW_AND) || (op == SW_OR) || (op == SW_XOR);
    endfunction

    function automatic logic [CCR_W-1:0] sw_apply(swop_e op, logic [CCR_W-1:0] cur,
                                                  logic [CCR_W-1:0] imm);
        case (op)
            SW_LOAD: return imm;
            SW_AND:  return cur & imm;
            SW_OR:   return cur | imm;
            SW_XOR:  return cur ^ imm;
            default: return cur;
        endcase
    endfunction

    function automatic int size_idx(size_e s);
        case (s)
            SZ_BYTE: return 0;
            SZ_WORD: return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/ccf_arith.sv
module ccf_arith
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  size_e             size,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output arith_t            flags
);

    logic              is_sub;
    logic [DATA_W-1:0] a_eff;
    arith_t            per_size [NSIZE];

    assign is_sub = (op == OP_SUB) || (op == OP_CMP) || (op == OP_NEG);
    assign a_eff  = (op == OP_NEG) ? '0 : opa;

    for (genvar g = 0; g < NSIZE; g++) begin : g_size
        localparam int W  = DATA_W >> (NSIZE - 1 - g);
        localparam int HP = W - 5;

        logic [W:0]    s_add;
        logic [W:0]    s_sub;
        logic [HP+1:0] h_add;
        logic [HP+1:0] h_sub;
        logic          v_add;
        logic          v_sub;

        assign s_add = {1'b0, a_eff[W-1:0]} + {1'b0, opb[W-1:0]};
        assign s_sub = {1'b0, a_eff[W-1:0]} - {1'b0, opb[W-1:0]};
        assign h_add = {1'b0, a_eff[HP:0]} + {1'b0, opb[HP:0]};
        assign h_sub = {1'b0, a_eff[HP:0]} - {1'b0, opb[HP:0]};

        assign v_add = ~(a_eff[W-1] ^ opb[W-1]) & (s_add[W-1] ^ a_eff[W-1]);
        assign v_sub =  (a_eff[W-1] ^ opb[W-1]) & (s_sub[W-1] ^ a_eff[W-1]);

        assign per_size[g].c = is_sub ? s_sub[W]    : s_add[W];
        assign per_size[g].v = is_sub ? v_sub       : v_add;
        assign per_size[g].h = is_sub ? h_sub[HP+1] : h_add[HP+1];
    end

    assign flags = per_size[size_idx(size)];

endmodule

// File: rtl/ccf_nz.sv
module ccf_nz
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e             size,
    input  logic [DATA_W-1:0] result,
    output nz_t               nz
);

    nz_t per_size [NSIZE];

    for (genvar g = 0; g < NSIZE; g++) begin : g_size
        localparam int W = DATA_W >> (NSIZE - 1 - g);
        assign per_size[g].n = result[W-1];
        assign per_size[g].z = (result[W-1:0] == '0);
    end

    assign nz = per_size[size_idx(size)];

endmodule

// File: rtl/ccf_merge.sv
module ccf_merge
    import ccf_pkg::*;
(
    input  op_e              op,
    input  logic [CCR_W-1:0] cur,
    input  arith_t           ar,
    input  nz_t              nz,
    input  logic             shout,
    output logic             we,
    output logic [CCR_W-1:0] nxt
);

    always_comb begin
        nxt = cur;
        we  = 1'b0;
        case (op)
            OP_ADD, OP_SUB, OP_CMP, OP_NEG: begin
                we       = 1'b1;
                nxt[B_H] = ar.h;
                nxt[B_N] = nz.n;
                nxt[B_Z] = nz.z;
                nxt[B_V] = ar.v;
                nxt[B_C] = ar.c;
            end
            OP_LOGIC: begin
                we       = 1'b1;
                nxt[B_N] = nz.n;
                nxt[B_Z] = nz.z;
                nxt[B_V] = 1'b0;
            end
            OP_SHIFT: begin
                we       = 1'b1;
                nxt[B_N] = nz.n;
                nxt[B_Z] = nz.z;
                nxt[B_V] = 1'b0;
                nxt[B_C] = shout;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ccf_reg.sv
module ccf_reg
    import ccf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_we,
    input  logic [CCR_W-1:0] flag_val,
    input  swop_e            sw_op,
    input  logic [CCR_W-1:0] sw_imm,
    output logic [CCR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q[B_I] <= 1'b1;
        end else if (sw_active(sw_op)) begin
            q <= sw_apply(sw_op, q, sw_imm);
        end else if (flag_we) begin
            q <= flag_val;
        end
    end

endmodule

// File: rtl/ccf_unit.sv
module ccf_unit
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              shout_i,
    input  logic [2:0]        sw_op_i,
    input  logic [7:0]        sw_imm_i,
    output logic [7:0]        ccr_o
);

    op_e              op;
    size_e            size;
    swop_e            sw_op;
    arith_t           ar;
    nz_t              nz;
    logic             flag_we;
    logic [CCR_W-1:0] flag_val;
    logic [CCR_W-1:0] ccr_q;

    assign op    = op_e'(op_i);
    assign size  = size_e'(size_i);
    assign sw_op = swop_e'(sw_op_i);

    ccf_arith #(.DATA_W(DATA_W)) u_arith (
        .op    (op),
        .size  (size),
        .opa   (opa_i),
        .opb   (opb_i),
        .flags (ar)
    );

    ccf_nz #(.DATA_W(DATA_W)) u_nz (
        .size   (size),
        .result (res_i),
        .nz     (nz)
    );

    ccf_merge u_merge (
        .op    (op),
        .cur   (ccr_q),
        .ar    (ar),
        .nz    (nz),
        .shout (shout_i),
        .we    (flag_we),
        .nxt   (flag_val)
    );

    ccf_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .flag_we  (flag_we),
        .flag_val (flag_val),
        .sw_op    (sw_op),
        .sw_imm   (sw_imm_i),
        .q        (ccr_q)
    );

    assign ccr_o = ccr_q;

endmodule

// File: rtl/ccf_unit_chk.sv
module ccf_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op_i,
    input logic       shout_i,
    input logic [2:0] sw_op_i,
    input logic [7:0] sw_imm_i,
    input logic [7:0] ccr_o
);

    logic sw_any;
    assign sw_any = (sw_op_i >= 3'd1) && (sw_op_i <= 3'd4);

    p_sw_load_r1: assert property (@(posedge clk) disable iff (rst)
        (sw_op_i == 3'd1) |=> (ccr_o == $past(sw_imm_i)));

    p_sw_xor_r2: assert property (@(posedge clk) disable iff (rst)
        (sw_op_i == 3'd4) |=> (ccr_o == ($past(ccr_o) ^ $past(sw_imm_i))));

    p_logic_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd5 && !sw_any) |=>
            (!ccr_o[1] && ccr_o[0] == $past(ccr_o[0]) && ccr_o[5] == $past(ccr_o[5])));

    p_shift_carry_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd6 && !sw_any) |=> (ccr_o[0] == $past(shout_i) && !ccr_o[1]));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ((op_i == 3'd0 || op_i == 3'd7) && !sw_any) |=> $stable(ccr_o));

    p_sw_bits_only_r10: assert property (@(posedge clk) disable iff (rst)
        (!sw_any) |=> (ccr_o[4] == $past(ccr_o[4]) && ccr_o[7:6] == $past(ccr_o[7:6])));

    p_reset_mask_r11: assert property (@(posedge clk)
        rst |=> ccr_o[7]);

    p_reset_keep_r11: assert property (@(posedge clk)
        rst |=> (ccr_o[6:0] == $past(ccr_o[6:0])));

endmodule

bind ccf_unit ccf_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .shout_i  (shout_i),
    .sw_op_i  (sw_op_i),
    .sw_imm_i (sw_imm_i),
    .ccr_o    (ccr_o)
);

// File: tb/tb_ccf_unit.sv
`timescale 1ns/1ps
module tb_ccf_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic [1:0]  size_i;
    logic [31:0] opa_i, opb_i, res_i;
    logic        shout_i;
    logic [2:0]  sw_op_i;
    logic [7:0]  sw_imm_i;
    logic [7:0]  ccr_o;

    always #10 clk = ~clk;

    ccf_unit dut (
        .clk(clk), .rst(rst), .op_i(op_i), .size_i(size_i), .opa_i(opa_i),
        .opb_i(opb_i), .res_i(res_i), .shout_i(shout_i), .sw_op_i(sw_op_i),
        .sw_imm_i(sw_imm_i), .ccr_o(ccr_o)
    );

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;

    item_t      sbq[$];
    logic [7:0] mdl;
    logic       mdl_known;
    int         n_checks = 0;
    int         n_fail   = 0;
    logic       done     = 1'b0;

    // driver: applies one cycle of stimulus and predicts the register
    task automatic drive(input int op, input int sz, input logic [31:0] a,
                         input logic [31:0] b, input logic sh, input int sw,
                         input logic [7:0] imm, input logic r, input string tag);
        int          w, hp;
        logic [63:0] m, hm, aa, bb, rr;
        logic        c, v, h;
        item_t       it;
        w  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        hp = w - 5;
        m  = (64'h1 << w) - 1;
        hm = (64'h1 << (hp + 1)) - 1;
        aa = (op == 4) ? 64'h0 : ({32'h0, a} & m);
        bb = {32'h0, b} & m;
        c = 0; v = 0; h = 0;
        if (op == 1) begin
            rr = aa + bb;
            c  = rr[w];
            h  = (((aa & hm) + (bb & hm)) >> (hp + 1)) != 0;
            v  = (aa[w-1] == bb[w-1]) && (rr[w-1] != aa[w-1]);
        end else if (op >= 2 && op <= 4) begin
            rr = aa - bb;
            c  = aa < bb;
            h  = (aa & hm) < (bb & hm);
            v  = (aa[w-1] != bb[w-1]) && (rr[w-1] != aa[w-1]);
        end else begin
            rr = {32'h0, a};
        end
        op_i = op[2:0]; size_i = sz[1:0]; opa_i = a; opb_i = b;
        res_i = (op >= 1 && op <= 4) ? (rr[31:0] | (a & ~m[31:0])) : a;
        shout_i = sh; sw_op_i = sw[2:0]; sw_imm_i = imm; rst = r;
        if (r) begin
            mdl[7] = 1'b1;
        end else if (sw >= 1 && sw <= 4) begin
            case (sw)
                1: begin mdl = imm; mdl_known = 1'b1; end
                2: mdl = mdl & imm;
                3: mdl = mdl | imm;
                default: mdl = mdl ^ imm;
            endcase
        end else if (op >= 1 && op <= 6) begin
            mdl[3] = rr[w-1];
            mdl[2] = (rr & m) == 0;
            if (op <= 4) begin
                mdl[5] = h; mdl[1] = v; mdl[0] = c;
            end else begin
                mdl[1] = 1'b0;
                if (op == 6) mdl[0] = sh;
            end
        end
        it.exp  = mdl;
        it.mask = mdl_known ? 8'hFF : 8'h80;
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    task automatic step(input int op, input int sz, input logic [31:0] a,
                        input logic [31:0] b, input logic sh, input string tag);
        @(negedge clk);
        drive(op, sz, a, b, sh, 0, 8'h00, 1'b0, tag);
    endtask

    task automatic swc(input int sw, input logic [7:0] imm, input string tag);
        @(negedge clk);
        drive(0, 0, 32'h0, 32'h0, 1'b0, sw, imm, 1'b0, tag);
    endtask

    // monitor: compares the register one edge after each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                n_checks++;
                if ((ccr_o & it.mask) !== (it.exp & it.mask)) begin
                    n_fail++;
                    $display("FAIL %s: ccr_o=%02h expected=%02h (mask %02h)",
                             it.tag, ccr_o, it.exp, it.mask);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        mdl = 8'h00; mdl_known = 1'b0;
        rst = 1'b1; op_i = 0; size_i = 0; opa_i = 0; opb_i = 0; res_i = 0;
        shout_i = 0; sw_op_i = 0; sw_imm_i = 0;
        @(negedge clk);
        drive(0, 0, 32'h0, 32'h0, 1'b0, 0, 8'h00, 1'b1, "R11 reset state");
        // R1 load and read back
        swc(1, 8'h00, "R1 load 00");
        swc(1, 8'h5A, "R1 load 5A");
        // R2 immediate logic on the register
        swc(2, 8'hF0, "R2 and F0");
        swc(3, 8'h0F, "R2 or 0F");
        swc(4, 8'hFF, "R2 xor FF");
        swc(1, 8'h00, "R1 load 00");
        // R4 add, half-carry per size
        step(1, 0, 32'h0F, 32'h01, 0, "R4 add byte nibble carry");
        step(1, 0, 32'h7F, 32'h01, 0, "R4 add byte overflow");
        step(1, 0, 32'hFF, 32'h01, 0, "R4 add byte carry zero");
        step(1, 1, 32'h0800, 32'h0800, 0, "R4 add word bit11 carry");
        step(1, 1, 32'h0008, 32'h0008, 0, "R4 add word bit3 no H");
        step(1, 2, 32'h0800_0000, 32'h0800_0000, 0, "R4 add long bit27 carry");
        step(1, 2, 32'h0000_0800, 32'h0000_0800, 0, "R4 add long bit11 no H");
        step(1, 2, 32'hFFFF_FFFF, 32'h0000_0001, 0, "R4 add long carry out");
        // R7 upper bits ignored
        step(1, 0, 32'hFFFF_FF01, 32'h0000_FF01, 0, "R7 add byte upper bits ignored");
        // R5 subtract and compare
        step(2, 0, 32'h00, 32'h01, 0, "R5 sub byte borrow");
        step(2, 1, 32'h8000, 32'h0001, 0, "R5 sub word overflow");
        step(3, 2, 32'h1234_5678, 32'h1234_5678, 0, "R5 cmp long equal");
        step(3, 1, 32'h1000, 32'h0001, 0, "R5 cmp word bit11 borrow");
        // R6 negate
        step(4, 0, 32'h0, 32'h80, 0, "R6 neg byte min");
        step(4, 1, 32'hFFFF, 32'h0000, 0, "R6 neg word zero");
        step(4, 2, 32'h0, 32'h0000_0001, 0, "R6 neg long one");
        // R8 logical keeps C and H, clears V
        swc(1, 8'h23, "R1 load 23");
        step(5, 0, 32'hFF00, 32'h0, 0, "R8 logic byte zero");
        step(5, 1, 32'h8000, 32'h0, 0, "R8 logic word negative");
        // R9 shift
        step(6, 0, 32'h80, 32'h0, 1, "R9 shift carry in");
        step(6, 2, 32'h0000_0001, 32'h0, 0, "R9 shift carry clear");
        // R10 idle and software-only bits
        swc(1, 8'h50, "R1 load 50");
        step(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R10 idle hold");
        step(7, 2, 32'h1, 32'h1, 1, "R10 reserved op hold");
        step(2, 0, 32'h00, 32'h01, 0, "R10 user bits kept by sub");
        // R3 software wins
        @(negedge clk);
        drive(1, 0, 32'hFF, 32'h01, 0, 1, 8'h81, 1'b0, "R3 load beats add");
        @(negedge clk);
        drive(6, 0, 32'h00, 32'h00, 1, 3, 8'h10, 1'b0, "R3 or beats shift");
        // R11 reset keeps low bits and overrides writes
        swc(1, 8'h35, "R1 load 35");
        @(negedge clk);
        drive(1, 0, 32'hFF, 32'h01, 0, 1, 8'h00, 1'b1, "R11 reset over load");
        @(negedge clk);
        drive(0, 0, 32'h0, 32'h0, 0, 0, 8'h00, 1'b0, "R11 after reset hold");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule